// File: doc/BRIEF.md
# Cache Block Maintenance Controller

This block performs per-block maintenance on a small four-way data cache tag array and issues set invalidations toward an instruction cache. A requester presents one command at a time: store-back (write a dirty block to memory but keep it), flush (write back if dirty and drop the block), touch (a prefetch hint) or instruction-set invalidate. With the command come the untranslated set index and, from an external translation stub, the translated block address and two protection fault flags.

The controller looks up the data tags, decides what the command needs, and then drives a single memory port for write-backs or touch fetches. It also drives a state-only update of the tag entry, a one-cycle broadcast request for the bus, a data storage exception with its cause, and an invalidate strobe for the instruction cache. A fill port lets the surrounding cache load tag and state into any set and way. Two configuration inputs select whether maintenance commands are broadcast and whether touch hints are turned into one-cycle no-ops.

Top module: `cbm_ctrl`

## Requirements
- R1: Commands are taken on `cmd_valid` while `cmd_ready` is high. `cmd_ready` drops in the cycle after acceptance and stays low until the cycle after `done`. `done` is a single-cycle pulse.
- R2: When a store-back hits a block in state M (2'b11), it issues a memory write (`mem_we`=1) to the block-aligned address. When `mem_ack` arrives it updates that way to state E (2'b01). `done` comes 3 cycles after acceptance plus one cycle for each cycle that `mem_ack` is late.
- R3: A store-back that hits in E or misses makes no memory request and no tag update. Its `done` comes 2 cycles after acceptance.
- R4: A flush that hits in M writes the block back and then sets the way to I (2'b00). A flush that hits in E sets the way to I with no memory access and `done` after 2 cycles. A flush that misses does nothing.
- R5: For a store-back or flush without a fault, `bc_req` is high during the `done` cycle exactly when `cfg_bcast_en` is 1, whether the command hits or misses, with `bc_op` equal to the command and `bc_addr` equal to the block address. Touch and invalidate never broadcast.
- R6: A store-back or flush that has a fault raises `exc_dsi` during `done`. `exc_cause` is 2'b01 when the block-translation fault is present (even if the TLB fault is also present) and 2'b10 for a TLB fault alone. The command makes no memory access, no tag update and no broadcast.
- R7: With `cfg_touch_nop`=1 at acceptance, a touch raises `done` one cycle after acceptance, with no memory request, no update and no broadcast.
- R8: With `cfg_touch_nop`=0, a touch that misses issues a memory read (`mem_we`=0) to the block address. A touch that hits, or that has a fault, does nothing and raises no exception. `mem_req` stays high until `mem_ack`.
- R9: An instruction-set invalidate raises `ic_inv` during `done` (2 cycles after acceptance), with `ic_inv_set` equal to `cmd_vidx`. It ignores both fault inputs, never raises an exception, never broadcasts and leaves the data tags unchanged.
- R10: After reset every data way is in state I. A fill writes the given tag and state into the given set and way. The lookup uses set = `xl_blk[2:0]` and tag = `xl_blk[26:3]`, and the lowest-numbered matching valid way wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command taken |
| cmd_op | input | 2 | 0 store-back, 1 flush, 2 touch, 3 instruction-set invalidate |
| cmd_vidx | input | 3 | Untranslated set index |
| xl_blk | input | 27 | Translated block address (address bits above the 5 offset bits) |
| xl_bat_fault | input | 1 | Block-translation protection fault |
| xl_tlb_fault | input | 1 | TLB protection fault |
| cfg_bcast_en | input | 1 | Broadcast enable for store-back and flush |
| cfg_touch_nop | input | 1 | Make touch commands no-ops |
| fill_valid | input | 1 | Tag fill strobe |
| fill_set | input | 3 | Fill set |
| fill_way | input | 2 | Fill way |
| fill_tag | input | 24 | Fill tag |
| fill_state | input | 2 | Fill state |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write-back, 0 touch fetch |
| mem_addr | output | 32 | Block-aligned memory address |
| mem_ack | input | 1 | Memory acknowledge |
| bc_req | output | 1 | Bus broadcast pulse |
| bc_op | output | 2 | Broadcast command |
| bc_addr | output | 32 | Broadcast block address |
| exc_dsi | output | 1 | Data storage exception pulse |
| exc_cause | output | 2 | 01 block-translation, 10 TLB |
| upd_valid | output | 1 | Tag state update pulse |
| upd_set | output | 3 | Updated set |
| upd_way | output | 2 | Updated way |
| upd_state | output | 2 | New state |
| ic_inv | output | 1 | Instruction cache set invalidate pulse |
| ic_inv_set | output | 3 | Set to invalidate |
| done | output | 1 | Command complete pulse |

## Verification
The hardest case to reach is a command that hits a way that an earlier command has just changed. Examples are a store-back on a block already demoted to E, or a flush on a block a previous flush removed. The stimulus keeps tags to a small pool, fills the sets heavily, and aims most addresses at filled lines, so random commands often land on blocks that earlier commands demoted or dropped. The bench tracks its own tag model to predict every such outcome. Directed sequences repeat a command on the same block, combine both faults, and stretch the memory acknowledge.

// File: rtl/cbm_pkg.sv
// Shared types for the cache block maintenance controller.
// Assumes a 2-bit MESI-style state code with only I, E and M in use.
package cbm_pkg;

    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_FLUSH = 2'd1,
        OP_TOUCH = 2'd2,
        OP_ICINV = 2'd3
    } cbm_op_e;

    localparam logic [1:0] ST_I = 2'b00;
    localparam logic [1:0] ST_E = 2'b01;
    localparam logic [1:0] ST_M = 2'b11;

    localparam logic [1:0] CAUSE_NONE = 2'b00;
    localparam logic [1:0] CAUSE_BAT  = 2'b01;
    localparam logic [1:0] CAUSE_TLB  = 2'b10;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOOK = 2'd1,
        S_MEM  = 2'd2,
        S_FIN  = 2'd3
    } cbm_fsm_e;

endpackage

// File: rtl/cbm_dtags.sv
// Data cache tag and state store with one lookup port and two write ports.
// Does:    combinational lookup, fill write (tag+state), update write (state only).
// Assumes: the update port wins over the fill port on the same entry; at most
//          one valid way per set matches a tag (lowest way chosen otherwise).
module cbm_dtags #(
    parameter int SET_W = 3,
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int NSETS = 1 << SET_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [WAY_W-1:0] lk_way,
    output logic [1:0]       lk_state,
    input  logic             fl_en,
    input  logic [SET_W-1:0] fl_set,
    input  logic [WAY_W-1:0] fl_way,
    input  logic [TAG_W-1:0] fl_tag,
    input  logic [1:0]       fl_state,
    input  logic             up_en,
    input  logic [SET_W-1:0] up_set,
    input  logic [WAY_W-1:0] up_way,
    input  logic [1:0]       up_state
);
    import cbm_pkg::*;

    logic [TAG_W-1:0] tag_q [NSETS][WAYS];
    logic [1:0]       st_q  [NSETS][WAYS];

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            logic up_hit, fl_hit;
            assign up_hit = up_en && (up_set == SET_W'(s)) && (up_way == WAY_W'(w));
            assign fl_hit = fl_en && (fl_set == SET_W'(s)) && (fl_way == WAY_W'(w));
            // Hold one entry: reset to invalid, then update or fill.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q[s][w] <= '0;
                    st_q[s][w]  <= ST_I;
                end else if (up_hit) begin
                    st_q[s][w]  <= up_state;
                end else if (fl_hit) begin
                    tag_q[s][w] <= fl_tag;
                    st_q[s][w]  <= fl_state;
                end
            end
        end
    end

    // Search the addressed set; scanning downward leaves the lowest way.
    always_comb begin
        lk_hit   = 1'b0;
        lk_way   = '0;
        lk_state = ST_I;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (st_q[lk_set][w] != ST_I && tag_q[lk_set][w] == lk_tag) begin
                lk_hit   = 1'b1;
                lk_way   = WAY_W'(w);
                lk_state = st_q[lk_set][w];
            end
        end
    end

endmodule

// File: rtl/cbm_fault_pri.sv
// Protection fault priority: the block-translation fault outranks the TLB fault.
// Assumes both flags are already qualified by the translation stub.
module cbm_fault_pri (
    input  logic       bat_fault,
    input  logic       tlb_fault,
    output logic       fault,
    output logic [1:0] cause
);
    import cbm_pkg::*;

    // Pick the highest-priority cause present.
    always_comb begin
        fault = bat_fault || tlb_fault;
        if (bat_fault)      cause = CAUSE_BAT;
        else if (tlb_fault) cause = CAUSE_TLB;
        else                cause = CAUSE_NONE;
    end

endmodule

// File: rtl/cbm_ctrl.sv
// Cache block maintenance controller (top).
// Does:    accepts one command at a time, looks up the data tags, runs a
//          write-back or touch fetch on the memory port, updates tag state,
//          and pulses broadcast, exception and instruction-invalidate outputs
//          together with done.
// Assumes: mem_ack only while mem_req is high; fills are not issued in the
//          cycle of a tag update to the same entry.
module cbm_ctrl #(
    parameter int ADDR_W = 32,
    parameter int BLK_W  = 5,
    parameter int SET_W  = 3,
    parameter int WAYS   = 4,
    localparam int BLK_AW = ADDR_W - BLK_W,
    localparam int TAG_W  = BLK_AW - SET_W,
    localparam int WAY_W  = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [SET_W-1:0]  cmd_vidx,
    input  logic [BLK_AW-1:0] xl_blk,
    input  logic              xl_bat_fault,
    input  logic              xl_tlb_fault,
    input  logic              cfg_bcast_en,
    input  logic              cfg_touch_nop,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [1:0]        fill_state,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              bc_req,
    output logic [1:0]        bc_op,
    output logic [ADDR_W-1:0] bc_addr,
    output logic              exc_dsi,
    output logic [1:0]        exc_cause,
    output logic              upd_valid,
    output logic [SET_W-1:0]  upd_set,
    output logic [WAY_W-1:0]  upd_way,
    output logic [1:0]        upd_state,
    output logic              ic_inv,
    output logic [SET_W-1:0]  ic_inv_set,
    output logic              done
);
    import cbm_pkg::*;

    cbm_fsm_e          st_q;
    cbm_op_e           op_q;
    logic [BLK_AW-1:0] blk_q;
    logic [SET_W-1:0]  vidx_q;
    logic              bat_q, tlb_q;
    logic              exc_q, upd_q, we_q;
    logic [1:0]        cause_q, ust_q;
    logic [WAY_W-1:0]  way_q;

    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [1:0]        lk_state;
    logic              fault;
    logic [1:0]        cause;
    logic              go_mem, exc_d, upd_d, we_d;
    logic [1:0]        ust_d;

    cbm_dtags #(.SET_W(SET_W), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_set   (blk_q[SET_W-1:0]),
        .lk_tag   (blk_q[BLK_AW-1:SET_W]),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .lk_state (lk_state),
        .fl_en    (fill_valid),
        .fl_set   (fill_set),
        .fl_way   (fill_way),
        .fl_tag   (fill_tag),
        .fl_state (fill_state),
        .up_en    (upd_valid),
        .up_set   (upd_set),
        .up_way   (upd_way),
        .up_state (upd_state)
    );

    cbm_fault_pri u_fault (
        .bat_fault (bat_q),
        .tlb_fault (tlb_q),
        .fault     (fault),
        .cause     (cause)
    );

    // Decide the action of the latched command from the lookup result.
    always_comb begin
        go_mem = 1'b0;
        exc_d  = 1'b0;
        upd_d  = 1'b0;
        ust_d  = ST_I;
        we_d   = 1'b1;
        case (op_q)
            OP_STORE: begin
                if (fault) begin
                    exc_d = 1'b1;
                end else if (lk_hit && lk_state == ST_M) begin
                    go_mem = 1'b1;
                    upd_d  = 1'b1;
                    ust_d  = ST_E;
                end
            end
            OP_FLUSH: begin
                if (fault) begin
                    exc_d = 1'b1;
                end else if (lk_hit) begin
                    upd_d  = 1'b1;
                    ust_d  = ST_I;
                    go_mem = (lk_state == ST_M);
                end
            end
            OP_TOUCH: begin
                if (!fault && !lk_hit) begin
                    go_mem = 1'b1;
                    we_d   = 1'b0;
                end
            end
            default: ;
        endcase
    end

    // Sequence a command through accept, lookup, memory and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            op_q    <= OP_STORE;
            blk_q   <= '0;
            vidx_q  <= '0;
            bat_q   <= 1'b0;
            tlb_q   <= 1'b0;
            exc_q   <= 1'b0;
            upd_q   <= 1'b0;
            we_q    <= 1'b1;
            cause_q <= CAUSE_NONE;
            ust_q   <= ST_I;
            way_q   <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= cbm_op_e'(cmd_op);
                    blk_q  <= xl_blk;
                    vidx_q <= cmd_vidx;
                    bat_q  <= xl_bat_fault;
                    tlb_q  <= xl_tlb_fault;
                    exc_q  <= 1'b0;
                    upd_q  <= 1'b0;
                    st_q   <= (cbm_op_e'(cmd_op) == OP_TOUCH && cfg_touch_nop) ? S_FIN : S_LOOK;
                end
                S_LOOK: begin
                    exc_q   <= exc_d;
                    cause_q <= cause;
                    upd_q   <= upd_d;
                    ust_q   <= ust_d;
                    way_q   <= lk_way;
                    we_q    <= we_d;
                    st_q    <= go_mem ? S_MEM : S_FIN;
                end
                S_MEM:  if (mem_ack) st_q <= S_FIN;
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Drive the port-side view of the sequencer state.
    always_comb begin
        cmd_ready  = (st_q == S_IDLE);
        done       = (st_q == S_FIN);
        mem_req    = (st_q == S_MEM);
        mem_we     = we_q;
        mem_addr   = {blk_q, {BLK_W{1'b0}}};
        bc_req     = done && !exc_q && cfg_bcast_en &&
                     (op_q == OP_STORE || op_q == OP_FLUSH);
        bc_op      = op_q;
        bc_addr    = mem_addr;
        exc_dsi    = done && exc_q;
        exc_cause  = exc_dsi ? cause_q : CAUSE_NONE;
        upd_valid  = done && upd_q;
        upd_set    = blk_q[SET_W-1:0];
        upd_way    = way_q;
        upd_state  = ust_q;
        ic_inv     = done && (op_q == OP_ICINV);
        ic_inv_set = vidx_q;
    end

endmodule

// File: rtl/cbm_chk.sv
// Protocol and rule checker for cbm_ctrl, attached by bind.
// Tracks the last accepted command on its own to relate outputs to it.
module cbm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic       cfg_touch_nop,
    input logic       cfg_bcast_en,
    input logic       done,
    input logic       mem_req,
    input logic       mem_ack,
    input logic       mem_we,
    input logic       bc_req,
    input logic       exc_dsi,
    input logic [1:0] exc_cause,
    input logic       upd_valid,
    input logic [1:0] upd_state,
    input logic       ic_inv
);
    import cbm_pkg::*;

    logic [1:0] last_op;

    // Remember the opcode of the command most recently accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                      last_op <= OP_STORE;
        else if (cmd_valid && cmd_ready) last_op <= cmd_op;
    end

    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_store_keeps_e_r2: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && last_op == OP_STORE |-> upd_state == ST_E);
    p_flush_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && last_op == OP_FLUSH |-> upd_state == ST_I);
    p_bcast_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bc_req |-> done && cfg_bcast_en && (last_op == OP_STORE || last_op == OP_FLUSH));
    p_exc_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_dsi |-> done && !bc_req && !upd_valid && exc_cause != CAUSE_NONE);
    p_touch_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_op == OP_TOUCH && cfg_touch_nop |=> done && !mem_req);
    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req);
    p_touch_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && last_op == OP_TOUCH |-> !mem_we);
    p_icinv_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ic_inv |-> done && !exc_dsi && !bc_req && !upd_valid && !mem_req);

endmodule

bind cbm_ctrl cbm_chk u_cbm_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_op        (cmd_op),
    .cfg_touch_nop (cfg_touch_nop),
    .cfg_bcast_en  (cfg_bcast_en),
    .done          (done),
    .mem_req       (mem_req),
    .mem_ack       (mem_ack),
    .mem_we        (mem_we),
    .bc_req        (bc_req),
    .exc_dsi       (exc_dsi),
    .exc_cause     (exc_cause),
    .upd_valid     (upd_valid),
    .upd_state     (upd_state),
    .ic_inv        (ic_inv)
);

// File: tb/test_cbm_ctrl.sv
`timescale 1ns/1ps
module test_cbm_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid, cmd_ready;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_vidx;
    logic [26:0] xl_blk;
    logic        xl_bat_fault, xl_tlb_fault;
    logic        cfg_bcast_en, cfg_touch_nop;
    logic        fill_valid;
    logic [2:0]  fill_set;
    logic [1:0]  fill_way;
    logic [23:0] fill_tag;
    logic [1:0]  fill_state;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, bc_addr;
    logic        bc_req;
    logic [1:0]  bc_op;
    logic        exc_dsi;
    logic [1:0]  exc_cause;
    logic        upd_valid;
    logic [2:0]  upd_set;
    logic [1:0]  upd_way, upd_state;
    logic        ic_inv;
    logic [2:0]  ic_inv_set;
    logic        done;

    cbm_ctrl i_cbm_ctrl (.*);

    always #4 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [23:0] mtag [8][4];
    logic [1:0]  mst  [8][4];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [2:0] s, input logic [1:0] w,
                        input logic [23:0] t, input logic [1:0] st);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = s; fill_way = w; fill_tag = t; fill_state = st;
        @(negedge clk);
        fill_valid = 1'b0;
        mtag[s][w] = t;
        mst[s][w]  = st;
    endtask

    task automatic run(input logic [1:0] op, input logic [2:0] vidx, input logic [26:0] blk,
                       input bit bat, input bit tlb, input bit nop, input bit bcen,
                       input int ackdly);
        logic [2:0]  s;
        logic [23:0] t;
        bit hit, fault;
        int hway, cyc, dly;
        logic [1:0] hst;
        int e_lat; bit e_mem, e_we, e_upd, e_exc, e_bc, e_ic;
        logic [1:0] e_ust, e_cause;
        bit s_mem, s_we, s_done, s_bc, s_exc, s_upd, s_ic;
        logic [31:0] s_maddr, s_baddr;
        logic [1:0] s_cause, s_ust, s_uway, s_bop;
        logic [2:0] s_uset, s_icset;
        string rq;

        s = blk[2:0]; t = blk[26:3];
        hit = 0; hway = 0; hst = 2'b00;
        for (int w = 3; w >= 0; w--)
            if (mst[s][w] != 2'b00 && mtag[s][w] == t) begin hit = 1; hway = w; hst = mst[s][w]; end
        fault = bat | tlb;
        e_lat = 2; e_mem = 0; e_we = 1; e_upd = 0; e_ust = 2'b00; e_exc = 0; e_cause = 2'b00;
        e_bc = 0; e_ic = 0;
        case (op)
            2'd0: begin
                rq = "R2";
                if (fault) begin e_exc = 1; rq = "R6"; end
                else begin
                    e_bc = bcen;
                    if (hit && hst == 2'b11) begin e_mem = 1; e_upd = 1; e_ust = 2'b01; end
                    else rq = "R3";
                end
            end
            2'd1: begin
                rq = "R4";
                if (fault) begin e_exc = 1; rq = "R6"; end
                else begin
                    e_bc = bcen;
                    if (hit) begin e_upd = 1; e_ust = 2'b00; e_mem = (hst == 2'b11); end
                end
            end
            2'd2: begin
                if (nop) begin e_lat = 1; rq = "R7"; end
                else begin
                    rq = "R8";
                    if (!fault && !hit) begin e_mem = 1; e_we = 0; end
                end
            end
            default: begin e_ic = 1; rq = "R9"; end
        endcase
        if (e_exc) e_cause = bat ? 2'b01 : 2'b10;
        if (e_mem) e_lat = 3 + ackdly;

        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = op; cmd_vidx = vidx; xl_blk = blk;
        xl_bat_fault = bat; xl_tlb_fault = tlb; cfg_touch_nop = nop; cfg_bcast_en = bcen;
        @(negedge clk);
        cmd_valid = 1'b0;
        xl_bat_fault = $urandom_range(0, 1); xl_tlb_fault = $urandom_range(0, 1);
        chk(cmd_ready == 1'b0, "R1", "busy after accept", cmd_ready, 0);
        cyc = 1; dly = ackdly;
        s_mem = 0; s_we = 0; s_done = 0; s_maddr = '0;
        while (cyc < 40 && !s_done) begin
            mem_ack = 1'b0;
            if (mem_req) begin
                s_mem = 1; s_we = mem_we; s_maddr = mem_addr;
                if (dly == 0) mem_ack = 1'b1; else dly--;
            end
            if (done) begin
                s_done = 1; s_bc = bc_req; s_bop = bc_op; s_baddr = bc_addr;
                s_exc = exc_dsi; s_cause = exc_cause; s_upd = upd_valid; s_ust = upd_state;
                s_uway = upd_way; s_uset = upd_set; s_ic = ic_inv; s_icset = ic_inv_set;
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        mem_ack = 1'b0;
        chk(s_done, "R1", "done seen", s_done, 1);
        chk(cyc == e_lat, rq, "latency", cyc, e_lat);
        chk(s_mem == e_mem, rq, "memory request", s_mem, e_mem);
        if (e_mem) begin
            chk(s_we == e_we, rq, "mem_we", s_we, e_we);
            chk(s_maddr == {blk, 5'b0}, rq, "mem_addr", s_maddr, {blk, 5'b0});
        end
        chk(s_bc == e_bc, "R5", "bc_req", s_bc, e_bc);
        if (e_bc) begin
            chk(s_bop == op && s_baddr == {blk, 5'b0}, "R5", "bc op/addr", {s_bop, s_baddr}, {op, blk, 5'b0});
        end
        chk(s_exc == e_exc && s_cause == e_cause, e_exc ? "R6" : rq, "exception/cause",
            {s_exc, s_cause}, {e_exc, e_cause});
        chk(s_upd == e_upd, rq, "upd_valid", s_upd, e_upd);
        if (e_upd) begin
            chk(s_ust == e_ust && s_uway == hway[1:0] && s_uset == s, rq, "upd state/way/set",
                {s_ust, s_uway, s_uset}, {e_ust, hway[1:0], s});
        end
        chk(s_ic == e_ic, "R9", "ic_inv", s_ic, e_ic);
        if (e_ic) chk(s_icset == vidx, "R9", "ic_inv_set", s_icset, vidx);
        @(negedge clk);
        chk(done == 1'b0 && cmd_ready == 1'b1, "R1", "done single pulse, ready back",
            {done, cmd_ready}, 2'b01);
        if (e_upd) mst[s][hway] = e_ust;
    endtask

    function automatic logic [26:0] pick_blk();
        logic [2:0] s;
        s = 3'($urandom_range(0, 7));
        if ($urandom_range(0, 9) < 8) return {mtag[s][$urandom_range(0, 3)], s};
        return {24'($urandom_range(0, 5)), s};
    endfunction

    initial begin
        #(8ns * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int s = 0; s < 8; s++)
            for (int w = 0; w < 4; w++) begin mtag[s][w] = '0; mst[s][w] = 2'b00; end
        rst_n = 1'b0; cmd_valid = 0; cmd_op = 0; cmd_vidx = 0; xl_blk = 0;
        xl_bat_fault = 0; xl_tlb_fault = 0; cfg_bcast_en = 0; cfg_touch_nop = 0;
        fill_valid = 0; fill_set = 0; fill_way = 0; fill_tag = 0; fill_state = 0; mem_ack = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_ready == 1 && done == 0 && mem_req == 0, "R1", "reset outputs",
            {cmd_ready, done, mem_req}, 3'b100);
        // R10: after reset every way is invalid, so a store-back of tag 0 misses.
        run(2'd0, 3'd0, 27'd0, 0, 0, 0, 0, 0);
        run(2'd1, 3'd0, 27'd0, 0, 0, 0, 1, 0);
        // R2 then R3: M demoted to E, second store-back quiet.
        fill(3'd2, 2'd1, 24'h00AB, 2'b11);
        run(2'd0, 3'd2, {24'h00AB, 3'd2}, 0, 0, 0, 1, 2);
        run(2'd0, 3'd2, {24'h00AB, 3'd2}, 0, 0, 0, 0, 0);
        // R4: flush E, then flush again misses; flush M writes back.
        run(2'd1, 3'd2, {24'h00AB, 3'd2}, 0, 0, 0, 0, 0);
        run(2'd1, 3'd2, {24'h00AB, 3'd2}, 0, 0, 0, 1, 0);
        fill(3'd5, 2'd3, 24'h0042, 2'b11);
        run(2'd1, 3'd5, {24'h0042, 3'd5}, 0, 0, 0, 0, 1);
        // R6: both faults give block-translation cause; TLB alone.
        fill(3'd1, 2'd0, 24'h0007, 2'b11);
        run(2'd0, 3'd1, {24'h0007, 3'd1}, 1, 1, 0, 1, 0);
        run(2'd1, 3'd1, {24'h0007, 3'd1}, 0, 1, 0, 1, 0);
        // R7, R8: touch as no-op, touch miss fetch, touch with fault.
        run(2'd2, 3'd3, {24'h0099, 3'd3}, 0, 0, 1, 1, 0);
        run(2'd2, 3'd3, {24'h0099, 3'd3}, 0, 0, 0, 1, 2);
        run(2'd2, 3'd3, {24'h0099, 3'd3}, 1, 0, 0, 0, 0);
        // R9: invalidate with faults present; data line in set 1 still M after.
        run(2'd3, 3'd6, {24'h0007, 3'd1}, 1, 1, 0, 1, 0);
        run(2'd0, 3'd1, {24'h0007, 3'd1}, 0, 0, 0, 0, 0);
        // Random phase.
        for (int i = 0; i < 40; i++)
            fill(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                 24'($urandom_range(0, 3)), 2'(($urandom_range(0, 2) == 2) ? 3 : $urandom_range(0, 1)));
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 7) == 0)
                fill(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                     24'($urandom_range(0, 3)), 2'(($urandom_range(0, 1) == 1) ? 3 : 1));
            run(2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)), pick_blk(),
                ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3));
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule